// File: doc/BRIEF.md
# Voltage and Clock Mode Sequencer

This block sits between a processor's power-management port and the board hardware that sets the CPU core voltage and the CPU clock. The processor presents a 2-bit mode code and pulses a strobe. The block captures the code and carries out the change in a safe order, so that the CPU never runs on a clock or supply that is moving. For the whole change it stops the clock with a synchronous gate. It switches the clock generator to a new frequency profile and resets that generator. It steps the rail between 1.5 V and 1.0 V. It reopens the clock only when the PLL reports lock and the rail comparators confirm that the target range has been reached.

The order depends on the direction of the move. When the CPU moves up to full speed, the rail is raised first, and the faster profile is applied only once the rail is confirmed in the 1.5 V range. When the CPU moves down, the slower profile is applied first, and the rail is lowered afterwards. A move between the two 1.0 V modes changes only the profile. Code 3 does not change the CPU mode. It copies a plane-control input to the secondary power plane output.

Top module: `pwr_mode_seq`

## Requirements
- R1: A mode code is captured only on a clock edge where `cmdStrobe` is high. A change on `cmdCode` without a strobe has no effect on any output.
- R2: Each code maps to a pair of `profileSel` and `lowVoltSel` values:
  - Code 0 gives profile 0 with `lowVoltSel`=0 (1.5 V, full speed).
  - Code 1 gives profile 1 with `lowVoltSel`=1 (1.0 V, medium speed).
  - Code 2 gives profile 2 with `lowVoltSel`=1 (1.0 V, low speed).
- R3: Code 3 copies `planeCtrlIn` to `planeOn` on the strobe edge, where 1 means on. On that strobe `profileSel` and `lowVoltSel` stay unchanged and `clkGate` does not rise.
- R4: An accepted mode change sets `clkGate` (1 = clock stopped) and `busy` on the strobe edge. Every change of `profileSel` or `lowVoltSel` happens while `clkGate` is 1.
- R5: Each profile change is followed by exactly one `clkGenReset` pulse. The pulse is RST_CYCLES cycles long (default 4) and falls entirely within the gated period.
- R6: `clkGate` stays at 1 after the reset pulse until `pllLocked` is seen high. It falls exactly once per transition.
- R7: On a move up to code 0, `lowVoltSel` is cleared first. The profile changes only after `rail1V5Ok` has been seen high.
- R8: On a move down from code 0, the profile changes first and `lowVoltSel` is set afterwards. `clkGate` is released only after `railAbove1V` has been seen low.
- R9: `busy` is 1 from the strobe edge until the clock is released. Strobes that arrive while `busy` is 1 are ignored.
- R10: A strobe that repeats the mode in effect causes no gating, no clock-generator reset and no profile change.
- R11: After reset, the block is in mode 0 with the plane off, the gate open and `busy` low:
  - `profileSel`=0
  - `lowVoltSel`=0
  - `clkGate`=0
  - `clkGenReset`=0
  - `planeOn`=0
  - `busy`=0

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset |
| cmdCode | input | 2 | Requested mode code from the processor port |
| cmdStrobe | input | 1 | Captures `cmdCode` when high at a clock edge |
| planeCtrlIn | input | 1 | Secondary plane request, used with code 3 |
| railAbove1V | input | 1 | Comparator: CPU rail still above the 1 V limit |
| rail1V5Ok | input | 1 | Comparator: CPU rail inside the 1.5 V range |
| pllLocked | input | 1 | Clock generator PLL lock flag |
| lowVoltSel | output | 1 | 1 selects the 1.0 V rail, 0 selects 1.5 V |
| profileSel | output | 2 | Clock generator frequency profile |
| clkGate | output | 1 | 1 stops the CPU clock synchronously |
| clkGenReset | output | 1 | Reset pulse to the clock generator |
| planeOn | output | 1 | Secondary power plane enable |
| busy | output | 1 | A transition is in progress |

## Verification
A wrong sequencer state shows up at the ports quickly:
- An illegal state shows within one cycle as a profile or voltage edge with `clkGate` low.
- A lost state shows as a reset pulse of the wrong length, or as a gate that never falls and leaves `busy` stuck high.

The bench models the rail comparators and the PLL lock flag, and records the cycle of every output edge. It can then check the order of the voltage and profile edges against the direction of the move. It also checks that the gate falls only after lock, and after the rail drops on a downward move. It includes a held-off lock, a strobe in the middle of a transition, and a repeated mode.

// File: rtl/pmseq_pkg.sv
package pmseq_pkg;

  localparam logic [1:0] MODE_FULL  = 2'b00;
  localparam logic [1:0] MODE_MED   = 2'b01;
  localparam logic [1:0] MODE_LOW   = 2'b10;
  localparam logic [1:0] MODE_PLANE = 2'b11;

  typedef enum logic [2:0] {
    SIdle,
    SWaitHi,
    SRstWait,
    SWaitLock,
    SWaitLo
  } seqState_t;

  typedef struct packed {
    logic acceptMode;
    logic loadPlane;
    logic setGate;
    logic clrGate;
    logic setLow;
    logic clrLow;
    logic loadProfile;
    logic startRst;
  } seqCtl_t;

endpackage

// File: rtl/pmseq_datapath.sv
module pmseq_datapath
  import pmseq_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqCtl_t    ctl,
  input  logic [1:0] cmdCode,
  input  logic       planeCtrlIn,
  output logic [1:0] tgtMode,
  output logic [1:0] profileSel,
  output logic       lowVoltSel,
  output logic       clkGate,
  output logic       clkGenReset,
  output logic       planeOn
);

  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] RST_LOAD = CW'(RST_CYCLES);

  logic [CW-1:0] rstCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtMode    <= MODE_FULL;
      profileSel <= MODE_FULL;
      lowVoltSel <= 1'b0;
      clkGate    <= 1'b0;
      planeOn    <= 1'b0;
      rstCnt     <= '0;
    end else begin
      if (ctl.acceptMode) tgtMode <= cmdCode;
      if (ctl.loadProfile) profileSel <= ctl.acceptMode ? cmdCode : tgtMode;
      if (ctl.setLow)      lowVoltSel <= 1'b1;
      else if (ctl.clrLow) lowVoltSel <= 1'b0;
      if (ctl.setGate)      clkGate <= 1'b1;
      else if (ctl.clrGate) clkGate <= 1'b0;
      if (ctl.loadPlane) planeOn <= planeCtrlIn;
      if (ctl.startRst)        rstCnt <= RST_LOAD;
      else if (rstCnt != '0)   rstCnt <= rstCnt - 1'b1;
    end
  end

  assign clkGenReset = (rstCnt != '0);

  // R4
  profile_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(profileSel) |-> clkGate);

  // R4
  volt_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lowVoltSel) |-> clkGate);

  // R5
  reset_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkGenReset |-> clkGate);

endmodule

// File: rtl/pmseq_control.sv
module pmseq_control
  import pmseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStrobe,
  input  logic [1:0] cmdCode,
  input  logic [1:0] tgtMode,
  input  logic       railAbove1V,
  input  logic       rail1V5Ok,
  input  logic       pllLocked,
  input  logic       clkGenReset,
  output seqCtl_t    ctl,
  output logic       busy
);

  seqState_t state, stateNext;
  logic downReg, downNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    downNext  = downReg;
    unique case (state)
      SIdle: begin
        if (cmdStrobe) begin
          if (cmdCode == MODE_PLANE) begin
            ctl.loadPlane = 1'b1;
          end else if (cmdCode != tgtMode) begin
            ctl.acceptMode = 1'b1;
            ctl.setGate    = 1'b1;
            if (cmdCode == MODE_FULL) begin
              ctl.clrLow = 1'b1;
              stateNext  = SWaitHi;
            end else begin
              ctl.loadProfile = 1'b1;
              ctl.startRst    = 1'b1;
              downNext        = (tgtMode == MODE_FULL);
              stateNext       = SRstWait;
            end
          end
        end
      end
      SWaitHi: begin
        if (rail1V5Ok) begin
          ctl.loadProfile = 1'b1;
          ctl.startRst    = 1'b1;
          downNext        = 1'b0;
          stateNext       = SRstWait;
        end
      end
      SRstWait: begin
        if (!clkGenReset) stateNext = SWaitLock;
      end
      SWaitLock: begin
        if (pllLocked) begin
          if (downReg) begin
            ctl.setLow = 1'b1;
            stateNext  = SWaitLo;
          end else begin
            ctl.clrGate = 1'b1;
            stateNext   = SIdle;
          end
        end
      end
      SWaitLo: begin
        if (!railAbove1V) begin
          ctl.clrGate = 1'b1;
          stateNext   = SIdle;
        end
      end
      default: stateNext = SIdle;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SIdle;
      downReg <= 1'b0;
    end else begin
      state   <= stateNext;
      downReg <= downNext;
    end
  end

  assign busy = (state != SIdle);

  // R5
  idle_no_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !clkGenReset);

  // R7
  up_waits_rail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == SWaitHi && !rail1V5Ok) |=> state == SWaitHi);

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pmseq_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cmdCode,
  input  logic       cmdStrobe,
  input  logic       planeCtrlIn,
  input  logic       railAbove1V,
  input  logic       rail1V5Ok,
  input  logic       pllLocked,
  output logic       lowVoltSel,
  output logic [1:0] profileSel,
  output logic       clkGate,
  output logic       clkGenReset,
  output logic       planeOn,
  output logic       busy
);

  seqCtl_t    ctl;
  logic [1:0] tgtMode;

  pmseq_control uCtl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdStrobe   (cmdStrobe),
    .cmdCode     (cmdCode),
    .tgtMode     (tgtMode),
    .railAbove1V (railAbove1V),
    .rail1V5Ok   (rail1V5Ok),
    .pllLocked   (pllLocked),
    .clkGenReset (clkGenReset),
    .ctl         (ctl),
    .busy        (busy)
  );

  pmseq_datapath #(.RST_CYCLES(RST_CYCLES)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .cmdCode     (cmdCode),
    .planeCtrlIn (planeCtrlIn),
    .tgtMode     (tgtMode),
    .profileSel  (profileSel),
    .lowVoltSel  (lowVoltSel),
    .clkGate     (clkGate),
    .clkGenReset (clkGenReset),
    .planeOn     (planeOn)
  );

endmodule

// File: tb/sim_pwr_mode_seq.sv
`timescale 1ns/1ps
module sim_pwr_mode_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cmdCode = 2'b00;
  logic cmdStrobe = 1'b0;
  logic planeCtrlIn = 1'b0;
  logic railAbove1V, rail1V5Ok, pllLocked;
  logic lowVoltSel, clkGate, clkGenReset, planeOn, busy;
  logic [1:0] profileSel;
  logic forceUnlock = 1'b0;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  pwr_mode_seq u0 (
    .clk(clk), .rstN(rstN), .cmdCode(cmdCode), .cmdStrobe(cmdStrobe),
    .planeCtrlIn(planeCtrlIn), .railAbove1V(railAbove1V), .rail1V5Ok(rail1V5Ok),
    .pllLocked(pllLocked), .lowVoltSel(lowVoltSel), .profileSel(profileSel),
    .clkGate(clkGate), .clkGenReset(clkGenReset), .planeOn(planeOn), .busy(busy)
  );

  // environment: rail comparators and PLL lock respond after a few cycles
  int hiCnt = 0, loCnt = 0, lockCnt = 0;
  always @(posedge clk) begin
    if (lowVoltSel === 1'b1) begin hiCnt <= 0; loCnt <= loCnt + 1; end
    else begin loCnt <= 0; hiCnt <= hiCnt + 1; end
    if (clkGenReset === 1'b1) lockCnt <= 0; else lockCnt <= lockCnt + 1;
  end
  assign rail1V5Ok   = (hiCnt >= 5);
  assign railAbove1V = (loCnt < 5);
  assign pllLocked   = (lockCnt >= 3) && !forceUnlock;

  // edge monitor
  int cyc = 0, profChanges = 0, voltChanges = 0, gateRises = 0, gateFalls = 0;
  int rstPulses = 0, rstRun = 0, lastRstLen = 0, tProf = 0, tVolt = 0, gateViol = 0;
  logic profRailOk = 1'b0, railAtFall = 1'b1, lockAtFall = 1'b0;
  logic [1:0] prevProf = 2'b00;
  logic prevLow = 1'b0, prevGate = 1'b0, prevRst = 1'b0;
  logic prevRailOk = 1'b0, prevRailAbove = 1'b1, prevLock = 1'b0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rstN) begin
      if (profileSel != prevProf) begin
        profChanges <= profChanges + 1; tProf <= cyc; profRailOk <= prevRailOk;
        if (!clkGate) gateViol <= gateViol + 1;
      end
      if (lowVoltSel != prevLow) begin
        voltChanges <= voltChanges + 1; tVolt <= cyc;
        if (!clkGate) gateViol <= gateViol + 1;
      end
      if (clkGenReset) begin
        rstRun <= rstRun + 1;
        if (!clkGate) gateViol <= gateViol + 1;
      end else if (prevRst) begin
        rstPulses <= rstPulses + 1; lastRstLen <= rstRun; rstRun <= 0;
      end
      if (!prevGate && clkGate) gateRises <= gateRises + 1;
      if (prevGate && !clkGate) begin
        gateFalls <= gateFalls + 1; railAtFall <= prevRailAbove; lockAtFall <= prevLock;
      end
    end
    prevProf <= profileSel; prevLow <= lowVoltSel; prevGate <= clkGate;
    prevRst <= clkGenReset; prevRailOk <= rail1V5Ok; prevRailAbove <= railAbove1V;
    prevLock <= pllLocked;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic pulseStrobe(input logic [1:0] c, input logic p);
    cmdCode = c; planeCtrlIn = p; cmdStrobe = 1'b1;
    tick(1);
    cmdStrobe = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 300) begin tick(1); n++; end
    if (busy) chk(1'b0, "R9 busy timeout", 1, 0);
    tick(2);
  endtask

  // vector: {cmd[1:0], planeIn, expProf[1:0], expLow, expPlane, kind[1:0]}
  // kind: 0 no transition, 1 up, 2 down, 3 lateral
  localparam int NV = 9;
  localparam logic [8:0] VEC [NV] = '{
    {2'b01, 1'b0, 2'b01, 1'b1, 1'b0, 2'd2},
    {2'b10, 1'b0, 2'b10, 1'b1, 1'b0, 2'd3},
    {2'b11, 1'b1, 2'b10, 1'b1, 1'b1, 2'd0},
    {2'b00, 1'b0, 2'b00, 1'b0, 1'b1, 2'd1},
    {2'b00, 1'b0, 2'b00, 1'b0, 1'b1, 2'd0},
    {2'b10, 1'b1, 2'b10, 1'b1, 1'b1, 2'd2},
    {2'b11, 1'b0, 2'b10, 1'b1, 1'b0, 2'd0},
    {2'b01, 1'b0, 2'b01, 1'b1, 1'b0, 2'd3},
    {2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 2'd1}
  };

  bit finished = 1'b0;

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(8);
    // R11 reset state
    chk(profileSel == 2'b00, "R11 profileSel", profileSel, 0);
    chk(lowVoltSel == 1'b0 && clkGate == 1'b0 && clkGenReset == 1'b0, "R11 volt/gate/reset",
        {lowVoltSel, clkGate, clkGenReset}, 0);
    chk(planeOn == 1'b0 && busy == 1'b0, "R11 plane/busy", {planeOn, busy}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [8:0] e;
      int bP, bV, bR, bF, bS, bViol;
      logic busyAfter, gateAfter;
      e = VEC[v];
      bP = profChanges; bV = voltChanges; bR = gateRises; bF = gateFalls;
      bS = rstPulses; bViol = gateViol;
      pulseStrobe(e[8:7], e[6]);
      busyAfter = busy; gateAfter = clkGate;
      waitIdle();
      chk(profileSel == e[5:4], "R2 profileSel", profileSel, e[5:4]);
      chk(lowVoltSel == e[3], "R2 lowVoltSel", lowVoltSel, e[3]);
      chk(planeOn == e[2], "R3 planeOn", planeOn, e[2]);
      chk(gateViol == bViol, "R4 edge while ungated", gateViol - bViol, 0);
      if (e[1:0] == 2'd0) begin
        // R3 and R10: nothing gated or reset
        chk(!busyAfter && gateRises == bR, "R10 no gating", gateRises - bR, 0);
        chk(profChanges == bP && rstPulses == bS, "R10 no profile/reset",
            profChanges - bP + rstPulses - bS, 0);
      end else begin
        chk(busyAfter && gateAfter, "R4 R9 gate+busy on strobe edge", {busyAfter, gateAfter}, 3);
        chk(rstPulses - bS == 1, "R5 one reset pulse", rstPulses - bS, 1);
        chk(lastRstLen == 4, "R5 reset length", lastRstLen, 4);
        chk(gateFalls - bF == 1 && lockAtFall, "R6 gate fall after lock", gateFalls - bF, 1);
        if (e[1:0] == 2'd1) begin
          chk(voltChanges - bV == 1 && tVolt < tProf, "R7 voltage before profile", tVolt, tProf);
          chk(profRailOk, "R7 profile after rail1V5Ok", profRailOk, 1);
        end else if (e[1:0] == 2'd2) begin
          chk(voltChanges - bV == 1 && tProf < tVolt, "R8 profile before voltage", tProf, tVolt);
          chk(railAtFall == 1'b0, "R8 ungate after rail drop", railAtFall, 0);
        end else begin
          chk(voltChanges == bV, "R2 lateral keeps voltage", voltChanges - bV, 0);
        end
      end
    end

    // R1: code change without strobe
    begin
      int bR;
      bR = gateRises;
      cmdCode = 2'b10;
      tick(10);
      chk(profileSel == 2'b00 && !busy && gateRises == bR, "R1 no strobe no change", profileSel, 0);
    end

    // R9: strobe during transition ignored
    begin
      int bP;
      bP = profChanges;
      pulseStrobe(2'b01, 1'b0);
      tick(2);
      chk(busy == 1'b1, "R9 busy mid transition", busy, 1);
      pulseStrobe(2'b10, 1'b0);
      waitIdle();
      chk(profileSel == 2'b01, "R9 mid strobe ignored", profileSel, 1);
      chk(profChanges - bP == 1, "R9 single profile change", profChanges - bP, 1);
      tick(10);
      chk(!busy && !clkGate, "R9 no deferred action", {busy, clkGate}, 0);
    end

    // R6: held-off lock keeps the clock gated
    forceUnlock = 1'b1;
    pulseStrobe(2'b10, 1'b0);
    tick(40);
    chk(clkGate == 1'b1 && busy == 1'b1, "R6 gate held without lock", {clkGate, busy}, 3);
    forceUnlock = 1'b0;
    waitIdle();
    chk(clkGate == 1'b0 && profileSel == 2'b10, "R6 release after lock", {clkGate, profileSel}, 2);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule